// File: doc/BRIEF.md
# Two-Target Nested-Priority Interrupt Controller

This block collects a set of level-sensitive interrupt lines and turns them into two request lines for a processor: a normal request and a fast request. Each source has its own enable bit, a 4-bit priority and a bit that routes it to one of the two requests. Each request line has its own priority threshold. A source only counts if its priority is strictly above the threshold of the request line it is routed to. A service routine raises the threshold to the priority it is handling so that only more urgent sources can interrupt it, and it restores the old threshold when it finishes. This allows nested service.

Every source line passes through a two-flop synchroniser before any decision is made. Requests are not latched: a request line stays high only as long as some source meets all of its conditions. For each target, a vector register names the winning source and its priority. Software reaches the per-source settings, the two thresholds, the two vectors and a read-only capability word through a plain register bus. Writes take one clock. Reads are combinational.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset both request lines are low, both thresholds read 0, every source configuration word reads 0 and both vector words read 0.
- R2: A change on a source input reaches the request lines after two rising clock edges. After only one edge the request lines still show the old state.
- R3: A source drives its target's request line only when all of these hold: its synchronised input is high, its enable bit is set, it is routed to that target, and its priority is above the target's threshold. A source with priority 0 never drives a request line.
- R4: A source whose priority equals its target's threshold is blocked.
- R5: The vector word of a target reads {priority[8:5], source index[4:0]} of the winning source and reads 0 when no source is eligible. The winner is the eligible source with the highest priority. When priorities are equal, the lowest source index wins.
- R6: A threshold write takes effect on the request lines and the vector words one cycle after the write. Raising the threshold to the active priority drops the request. Lowering it again brings back pending sources of lower priority.
- R7: The threshold words are at word addresses 32 (normal target) and 33 (fast target). Only bits 3:0 are stored. Bits above bit 3 read as 0 whatever was written to them.
- R8: The capability word at address 36 reads 0x00010F1C. This encodes 28 sources in bits 7:0, a top priority of 15 in bits 15:8 and the target count minus one in bits 21:16.
- R9: The request lines follow the source level. When an eligible source drops and no other source is eligible, its request line goes low two edges later.
- R10: Source n (0 to 27) is configured at word address n with the priority in bits 3:0, the enable in bit 8 and the target in bit 16 (0 = normal, 1 = fast). All other bits read 0. The vector words are at addresses 34 (normal) and 35 (fast). Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 28 | Level-sensitive interrupt source lines, asynchronous |
| bus_wr | input | 1 | Register write strobe, one word per cycle |
| bus_addr | input | 6 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Normal-target request line |
| fiq_o | output | 1 | Fast-target request line |

## Verification
The bench sets up a fixed mix of priorities, routes and enables that includes two sources sharing a priority on one target, a source with priority 0 and a disabled source. It then walks the source patterns and thresholds of a table against a model built from the requirements. A design that broke ties toward the higher index, or that used a greater-or-equal compare for the threshold, would report the wrong vector or raise a request at an equal threshold. Directed cases check the two-edge latency, the threshold raise and restore during nested service, the bits above the threshold that must read zero, and the capability word. A design missing a synchroniser stage would answer one edge early, and one that stored the upper bits would read them back.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int DEF_NUM_SRC = 28;
  localparam int DEF_PRIO_W  = 4;
  localparam int BUS_W       = 32;
  localparam int ADDR_W      = 6;
  localparam int NUM_TGT     = 2;
  localparam int REG_BASE    = 32;
  localparam int CFG_EN_BIT  = 8;
  localparam int CFG_TGT_BIT = 16;
endpackage

// File: rtl/pic_sync.sv
module pic_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;
  logic [1:0]   warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
      warm   <= '0;
    end else begin
      stage1 <= d_i;
      stage2 <= stage1;
      if (warm != 2'd2) warm <= warm + 2'd1;
    end
  end

  assign q_o = stage2;

  // R2
  sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int NUM_SRC = 28,
  parameter int PRIO_W  = 4,
  parameter bit TGT_ID  = 1'b0,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int VEC_W  = PRIO_W + IDX_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SRC-1:0]              pend_i,
  input  logic [NUM_SRC-1:0]              en_i,
  input  logic [NUM_SRC-1:0]              tgt_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_i,
  input  logic [PRIO_W-1:0]               limit_i,
  output logic                            req_o,
  output logic [VEC_W-1:0]                vec_o
);
  logic [PRIO_W-1:0] best_p;
  logic [IDX_W-1:0]  best_i;

  // Strict greater-than keeps the first (lowest-index) source on a tie.
  always_comb begin
    best_p = '0;
    best_i = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend_i[i] && en_i[i] && (tgt_i[i] == TGT_ID) &&
          (prio_i[i] > limit_i) && (prio_i[i] > best_p)) begin
        best_p = prio_i[i];
        best_i = IDX_W'(i);
      end
    end
  end

  assign req_o = |best_p;
  assign vec_o = {best_p, best_i};

  // R3 R4
  win_above_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (vec_o[VEC_W-1:IDX_W] > limit_i));

  // R3 R5
  win_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (pend_i[vec_o[IDX_W-1:0]] && en_i[vec_o[IDX_W-1:0]] &&
               (tgt_i[vec_o[IDX_W-1:0]] == TGT_ID) &&
               (prio_i[vec_o[IDX_W-1:0]] == vec_o[VEC_W-1:IDX_W])));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_SRC = DEF_NUM_SRC,
  parameter int PRIO_W  = DEF_PRIO_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic               irq_o,
  output logic               fiq_o
);
  localparam int IDX_W = $clog2(NUM_SRC);
  localparam int VEC_W = PRIO_W + IDX_W;
  localparam logic [ADDR_W-1:0] A_LIM0 = ADDR_W'(REG_BASE);
  localparam logic [ADDR_W-1:0] A_VEC0 = ADDR_W'(REG_BASE + NUM_TGT);
  localparam logic [ADDR_W-1:0] A_FEAT = ADDR_W'(REG_BASE + 2 * NUM_TGT);
  localparam logic [ADDR_W-1:0] A_NSRC = ADDR_W'(NUM_SRC);
  localparam logic [BUS_W-1:0]  FEAT_WORD =
    {10'd0, 6'(NUM_TGT - 1), 8'((1 << PRIO_W) - 1), 8'(NUM_SRC)};

  logic [NUM_SRC-1:0]             pend;
  logic [NUM_SRC-1:0][PRIO_W-1:0] cfg_prio;
  logic [NUM_SRC-1:0]             cfg_en;
  logic [NUM_SRC-1:0]             cfg_tgt;
  logic [NUM_TGT-1:0][PRIO_W-1:0] lim;
  logic [NUM_TGT-1:0]             req;
  logic [NUM_TGT-1:0][VEC_W-1:0]  vec;

  pic_sync #(.W(NUM_SRC)) i_sync (
    .clk(clk), .rst_n(rst_n), .d_i(src_i), .q_o(pend)
  );

  // Source configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_prio <= '0;
      cfg_en   <= '0;
      cfg_tgt  <= '0;
    end else if (bus_wr && (bus_addr < A_NSRC)) begin
      cfg_prio[bus_addr[IDX_W-1:0]] <= bus_wdata[PRIO_W-1:0];
      cfg_en[bus_addr[IDX_W-1:0]]   <= bus_wdata[CFG_EN_BIT];
      cfg_tgt[bus_addr[IDX_W-1:0]]  <= bus_wdata[CFG_TGT_BIT];
    end
  end

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    localparam logic [ADDR_W-1:0] A_LIM = A_LIM0 + ADDR_W'(t);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        lim[t] <= '0;
      else if (bus_wr && bus_addr == A_LIM) lim[t] <= bus_wdata[PRIO_W-1:0];
    end

    pic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .TGT_ID(bit'(t))) i_arb (
      .clk(clk), .rst_n(rst_n), .pend_i(pend), .en_i(cfg_en), .tgt_i(cfg_tgt),
      .prio_i(cfg_prio), .limit_i(lim[t]), .req_o(req[t]), .vec_o(vec[t])
    );

    // R6 R7
    lim_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_LIM) |=> (lim[t] == $past(bus_wdata[PRIO_W-1:0])));
  end

  assign irq_o = req[0];
  assign fiq_o = req[1];

  // Register read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_addr < A_NSRC) begin
      bus_rdata[PRIO_W-1:0]  = cfg_prio[bus_addr[IDX_W-1:0]];
      bus_rdata[CFG_EN_BIT]  = cfg_en[bus_addr[IDX_W-1:0]];
      bus_rdata[CFG_TGT_BIT] = cfg_tgt[bus_addr[IDX_W-1:0]];
    end else if (bus_addr == A_LIM0) begin
      bus_rdata[PRIO_W-1:0] = lim[0];
    end else if (bus_addr == A_LIM0 + 1'b1) begin
      bus_rdata[PRIO_W-1:0] = lim[1];
    end else if (bus_addr == A_VEC0) begin
      bus_rdata[VEC_W-1:0] = vec[0];
    end else if (bus_addr == A_VEC0 + 1'b1) begin
      bus_rdata[VEC_W-1:0] = vec[1];
    end else if (bus_addr == A_FEAT) begin
      bus_rdata = FEAT_WORD;
    end
  end

  // R1 R9
  req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> (!irq_o && !fiq_o));
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [27:0] src_i = '0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  // Bench configuration, R10 layout
  function automatic logic [3:0] p_of(int i); return 4'((i * 5 + 3) % 16); endfunction
  function automatic logic t_of(int i); return (i % 3) == 0; endfunction
  function automatic logic e_of(int i); return i != 5; endfunction

  // Reference from R3 R4 R5
  function automatic logic [8:0] model(logic [27:0] m, logic [3:0] lim, logic tg);
    logic [3:0] bp = '0;
    logic [4:0] bi = '0;
    for (int i = 0; i < 28; i++)
      if (m[i] && e_of(i) && t_of(i) == tg && p_of(i) > lim && p_of(i) > bp) begin
        bp = p_of(i); bi = 5'(i);
      end
    return {bp, bi};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic set_src(logic [27:0] m);
    @(negedge clk); src_i = m;
    @(negedge clk); @(negedge clk);
  endtask

  // {source mask, normal threshold, fast threshold}
  localparam logic [35:0] VECS [8] = '{
    36'hFFFFFFF_00, 36'h0020002_00, 36'h0000001_00, 36'h0000200_00,
    36'h0000020_00, 36'hFFFFFFF_CE, 36'hFFFFFFF_FF, 36'h0010001_22
  };

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irq", 32'(irq_o), 0);
    check("R1 fiq", 32'(fiq_o), 0);
    rd(6'd32, r); check("R1 lim0", r, 0);
    rd(6'd33, r); check("R1 lim1", r, 0);
    rd(6'd7, r);  check("R1 cfg", r, 0);
    rd(6'd34, r); check("R1 vec0", r, 0);
    rd(6'd35, r); check("R1 vec1", r, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 28; i++)
      wr(6'(i), (32'(t_of(i)) << 16) | (32'(e_of(i)) << 8) | 32'(p_of(i)));
    // R10 readback
    rd(6'd1, r);  check("R10 cfg1", r, 32'h0000_0108);
    rd(6'd12, r); check("R10 cfg12", r, 32'h0001_010F);
    rd(6'd5, r);  check("R10 cfg5", r, 32'h0000_000C);
    rd(6'd40, r); check("R10 unmapped", r, 0);

    // Table walk: R3 R4 R5
    for (int k = 0; k < 8; k++) begin
      logic [27:0] m;
      logic [3:0] l0, l1;
      logic [8:0] e0, e1;
      {m, l0, l1} = VECS[k];
      wr(6'd32, 32'(l0));
      wr(6'd33, 32'(l1));
      set_src(m);
      e0 = model(m, l0, 1'b0);
      e1 = model(m, l1, 1'b1);
      check("R3 irq", 32'(irq_o), 32'(e0 != 0));
      check("R3 fiq", 32'(fiq_o), 32'(e1 != 0));
      rd(6'd34, r); check("R5 vec0", r, 32'(e0));
      rd(6'd35, r); check("R5 vec1", r, 32'(e1));
    end
    wr(6'd32, 0); wr(6'd33, 0);
    set_src('0);

    // R2 latency: source 1 (prio 8, normal)
    @(negedge clk); src_i = 28'h0000002;
    @(posedge clk); #2; check("R2 one edge", 32'(irq_o), 0);
    @(posedge clk); #2; check("R2 two edges", 32'(irq_o), 1);
    // R9 level drop
    @(negedge clk); src_i = '0;
    @(posedge clk); #2; check("R9 one edge", 32'(irq_o), 1);
    @(posedge clk); #2; check("R9 two edges", 32'(irq_o), 0);

    // R6 nested: sources 12 (15) and 3 (2), fast target
    set_src(28'h0001008);
    rd(6'd35, r); check("R6 start", r, {23'd0, 4'd15, 5'd12});
    wr(6'd33, 15);
    check("R6 raise", 32'(fiq_o), 0);
    wr(6'd33, 1);
    check("R6 restore", 32'(fiq_o), 1);
    rd(6'd35, r); check("R6 vec", r, {23'd0, 4'd15, 5'd12});
    set_src(28'h0000008);
    wr(6'd33, 2);
    check("R4 equal blocked", 32'(fiq_o), 0);
    wr(6'd33, 1);
    rd(6'd35, r); check("R6 lower exposed", r, {23'd0, 4'd2, 5'd3});

    // R7 upper bits
    wr(6'd32, 32'hFFFF_FFF7);
    rd(6'd32, r); check("R7 lim0", r, 32'h7);
    // R8 capability
    rd(6'd36, r); check("R8 features", r, 32'h0001_0F1C);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule